// File: doc/BRIEF.md
# SHA-512 Block Compression Core

This core runs the SHA-512 compression function on one 1024-bit block that has already been padded. After a one-cycle start it spends 80 clock cycles on the 80 rounds, one round per cycle, and then adds the result into its 512-bit chaining value. A flag given with the start selects the starting chaining value. When the flag is set, the block is the first of a message and the standard initial hash value is used. When the flag is clear, the chaining value left by the previous block is used. A longer message is therefore hashed by feeding its blocks one after another, with the flag set only on the first.

To keep one round inside one short cycle, the round constant, the expanded message word, the word that will become H and, on the last round, the first chaining word are summed one cycle ahead into a single registered operand. The new A word then needs only five operands: that precomputed term and the outputs of the two sigma functions and the two logic functions. These five operands pass through a per-column 5-to-3 counter, one carry-save stage and one carry-propagate adder. The message schedule is a 16-word window that shifts by one word each round.

Top module: `sha512_core`

## Requirements
- R1: While reset is held and after it is released, `done_o` is low and `hash_o` is all zeros.
- R2: A start with `first_i` high compresses `block_i` starting from the standard SHA-512 initial hash value. The one-block padded message "abc" yields the published digest. `block_i[1023:960]` is message word 0 and `block_i[63:0]` is word 15. `hash_o[511:448]` is chaining word 0 and `hash_o[63:0]` is word 7.
- R3: A start with `first_i` low compresses `block_i` starting from the current `hash_o`, so a two-block message is hashed correctly.
- R4: `start_i` is sampled at a rising edge when the core is idle. `done_o` is high for exactly one cycle, which begins at the 80th rising edge after the one that sampled the start. `hash_o` shows the new chaining value from that same edge.
- R5: `hash_o` changes only at the edge that raises `done_o`. During a run it keeps the previous result.
- R6: A start raised while a run is in progress is ignored. The run completes with the result and the timing of the original start.
- R7: The five-operand adder returns the sum of its operands modulo 2^W for any operand values.
- R8: Message words 16 to 79 follow the SHA-512 schedule recurrence, so random blocks give the same digest as a reference compression function.
- R9: A start given in the cycle in which `done_o` is high is accepted. The next run then follows back-to-back with the same 80-cycle timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin compressing `block_i` (accepted when idle) |
| first_i | input | 1 | High: start from the initial hash value; low: chain from `hash_o` |
| block_i | input | 1024 | Padded message block, word 0 in the top 64 bits |
| done_o | output | 1 | One-cycle pulse when the new chaining value is ready |
| hash_o | output | 512 | Chaining value / digest, word 0 in the top 64 bits |

## Verification
The core is built with its fixed 64-bit word and 80 rounds. This brings the one-block "abc" vector, random single blocks and chained second blocks within reach, and each result is compared against a compression function written in the bench. A separate adder instance at W = 64 is driven with random operands and all-ones operands, so that the counter's bit columns, the columns near the top and the dropped carries above bit 63 are all exercised. Directed runs place a second start in the middle of a run and another start in the done cycle, to check the acceptance rule and the timing of the pulse.

// File: rtl/sha512_core_pkg.sv
// Shared word type, round functions, initial hash value and round
// constants for the SHA-512 core. Assumes 64-bit words and 80 rounds.
package sha512_core_pkg;

    localparam int WORD_W  = 64;
    localparam int N_STEPS = 80;
    localparam int N_MSG   = 16;
    localparam int STEP_W  = $clog2(N_STEPS + 1);

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
    endfunction

    function automatic word_t small_sig0(input word_t x);
        return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
    endfunction

    function automatic word_t small_sig1(input word_t x);
        return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
    endfunction

    function automatic word_t choose(input word_t e, input word_t f, input word_t g);
        return (e & f) ^ (~e & g);
    endfunction

    function automatic word_t majority(input word_t a, input word_t b, input word_t c);
        return (a & b) ^ (a & c) ^ (b & c);
    endfunction

    // Initial hash value word i
    function automatic word_t init_word(input int i);
        case (i)
            0: return 64'h6a09e667f3bcc908;
            1: return 64'hbb67ae8584caa73b;
            2: return 64'h3c6ef372fe94f82b;
            3: return 64'ha54ff53a5f1d36f1;
            4: return 64'h510e527fade682d1;
            5: return 64'h9b05688c2b3e6c1f;
            6: return 64'h1f83d9abfb41bd6b;
            default: return 64'h5be0cd19137e2179;
        endcase
    endfunction

    // Round constants, lower half of the step range
    function automatic word_t const_lo(input logic [STEP_W-1:0] t);
        case (t)
            7'd0:  return 64'h428a2f98d728ae22;  7'd1:  return 64'h7137449123ef65cd;
            7'd2:  return 64'hb5c0fbcfec4d3b2f;  7'd3:  return 64'he9b5dba58189dbbc;
            7'd4:  return 64'h3956c25bf348b538;  7'd5:  return 64'h59f111f1b605d019;
            7'd6:  return 64'h923f82a4af194f9b;  7'd7:  return 64'hab1c5ed5da6d8118;
            7'd8:  return 64'hd807aa98a3030242;  7'd9:  return 64'h12835b0145706fbe;
            7'd10: return 64'h243185be4ee4b28c;  7'd11: return 64'h550c7dc3d5ffb4e2;
            7'd12: return 64'h72be5d74f27b896f;  7'd13: return 64'h80deb1fe3b1696b1;
            7'd14: return 64'h9bdc06a725c71235;  7'd15: return 64'hc19bf174cf692694;
            7'd16: return 64'he49b69c19ef14ad2;  7'd17: return 64'hefbe4786384f25e3;
            7'd18: return 64'h0fc19dc68b8cd5b5;  7'd19: return 64'h240ca1cc77ac9c65;
            7'd20: return 64'h2de92c6f592b0275;  7'd21: return 64'h4a7484aa6ea6e483;
            7'd22: return 64'h5cb0a9dcbd41fbd4;  7'd23: return 64'h76f988da831153b5;
            7'd24: return 64'h983e5152ee66dfab;  7'd25: return 64'ha831c66d2db43210;
            7'd26: return 64'hb00327c898fb213f;  7'd27: return 64'hbf597fc7beef0ee4;
            7'd28: return 64'hc6e00bf33da88fc2;  7'd29: return 64'hd5a79147930aa725;
            7'd30: return 64'h06ca6351e003826f;  7'd31: return 64'h142929670a0e6e70;
            7'd32: return 64'h27b70a8546d22ffc;  7'd33: return 64'h2e1b21385c26c926;
            7'd34: return 64'h4d2c6dfc5ac42aed;  7'd35: return 64'h53380d139d95b3df;
            7'd36: return 64'h650a73548baf63de;  7'd37: return 64'h766a0abb3c77b2a8;
            7'd38: return 64'h81c2c92e47edaee6;  7'd39: return 64'h92722c851482353b;
            default: return '0;
        endcase
    endfunction

    // Round constants, upper half of the step range
    function automatic word_t const_hi(input logic [STEP_W-1:0] t);
        case (t)
            7'd40: return 64'ha2bfe8a14cf10364;  7'd41: return 64'ha81a664bbc423001;
            7'd42: return 64'hc24b8b70d0f89791;  7'd43: return 64'hc76c51a30654be30;
            7'd44: return 64'hd192e819d6ef5218;  7'd45: return 64'hd69906245565a910;
            7'd46: return 64'hf40e35855771202a;  7'd47: return 64'h106aa07032bbd1b8;
            7'd48: return 64'h19a4c116b8d2d0c8;  7'd49: return 64'h1e376c085141ab53;
            7'd50: return 64'h2748774cdf8eeb99;  7'd51: return 64'h34b0bcb5e19b48a8;
            7'd52: return 64'h391c0cb3c5c95a63;  7'd53: return 64'h4ed8aa4ae3418acb;
            7'd54: return 64'h5b9cca4f7763e373;  7'd55: return 64'h682e6ff3d6b2b8a3;
            7'd56: return 64'h748f82ee5defb2fc;  7'd57: return 64'h78a5636f43172f60;
            7'd58: return 64'h84c87814a1f0ab72;  7'd59: return 64'h8cc702081a6439ec;
            7'd60: return 64'h90befffa23631e28;  7'd61: return 64'ha4506cebde82bde9;
            7'd62: return 64'hbef9a3f7b2c67915;  7'd63: return 64'hc67178f2e372532b;
            7'd64: return 64'hca273eceea26619c;  7'd65: return 64'hd186b8c721c0c207;
            7'd66: return 64'heada7dd6cde0eb1e;  7'd67: return 64'hf57d4f7fee6ed178;
            7'd68: return 64'h06f067aa72176fba;  7'd69: return 64'h0a637dc5a2c898a6;
            7'd70: return 64'h113f9804bef90dae;  7'd71: return 64'h1b710b35131c471b;
            7'd72: return 64'h28db77f523047d84;  7'd73: return 64'h32caab7b40c72493;
            7'd74: return 64'h3c9ebe0a15c9bebc;  7'd75: return 64'h431d67c49c100d4c;
            7'd76: return 64'h4cc5d4becb3e42b6;  7'd77: return 64'h597f299cfc657e2a;
            7'd78: return 64'h5fcb6fab3ad6faec;  7'd79: return 64'h6c44198c4a475817;
            default: return '0;
        endcase
    endfunction

    // Round constant for step t; zero outside 0..79
    function automatic word_t step_const(input logic [STEP_W-1:0] t);
        if (t < STEP_W'(40))
            return const_lo(t);
        return const_hi(t);
    endfunction

endpackage

// File: rtl/sha512_add5.sv
// Five-operand modulo-2^W adder: a per-column 5-to-3 counter, one
// 3-to-2 carry-save stage, then a single carry-propagate add.
// Assumes W >= 3. Weights above bit W-1 are dropped.
module sha512_add5 #(
    parameter int W = 64
) (
    input  logic [4:0][W-1:0] ops_i,
    output logic [W-1:0]      sum_o
);

    logic [W-1:0] col0;
    logic [W-1:0] col1;
    logic [W-1:0] col2;
    logic [W-1:0] cs_sum;
    logic [W-2:0] cs_maj;

    assign col1[0]   = 1'b0;
    assign col2[1:0] = 2'b00;

    // Count the ones in each bit column and spread the count over three weights
    for (genvar i = 0; i < W; i++) begin : g_col
        if (i < W - 2) begin : g_full
            logic [2:0] cnt;
            assign cnt = {2'b00, ops_i[0][i]} + {2'b00, ops_i[1][i]} + {2'b00, ops_i[2][i]}
                       + {2'b00, ops_i[3][i]} + {2'b00, ops_i[4][i]};
            assign col0[i]   = cnt[0];
            assign col1[i+1] = cnt[1];
            assign col2[i+2] = cnt[2];
        end else if (i == W - 2) begin : g_two
            logic [1:0] cnt;
            assign cnt = {1'b0, ops_i[0][i]} + {1'b0, ops_i[1][i]} + {1'b0, ops_i[2][i]}
                       + {1'b0, ops_i[3][i]} + {1'b0, ops_i[4][i]};
            assign col0[i]   = cnt[0];
            assign col1[i+1] = cnt[1];
        end else begin : g_one
            assign col0[i] = ops_i[0][i] ^ ops_i[1][i] ^ ops_i[2][i] ^ ops_i[3][i] ^ ops_i[4][i];
        end
    end

    // Carry-save stage: three rows to sum and carry
    assign cs_sum = col0 ^ col1 ^ col2;
    assign cs_maj = (col0[W-2:0] & col1[W-2:0]) | (col0[W-2:0] & col2[W-2:0])
                  | (col1[W-2:0] & col2[W-2:0]);

    // Final carry-propagate add
    assign sum_o = cs_sum + {cs_maj, 1'b0};

endmodule

// File: rtl/sha512_expander.sv
// Message schedule as a sliding 16-word window. On load the window takes
// words 1..16 of the block; each shift drops the oldest word and appends the
// next one. head_o is the word for the round after the current one.
module sha512_expander
    import sha512_core_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    shift_i,
    input  logic [N_MSG*WORD_W-1:0] block_i,
    output word_t                   head_o
);

    word_t msg_w [N_MSG];
    word_t win_q [N_MSG];
    word_t msg_next;
    word_t win_next;

    for (genvar i = 0; i < N_MSG; i++) begin : g_unpack
        assign msg_w[i] = block_i[N_MSG*WORD_W-1-WORD_W*i -: WORD_W];
    end

    // Schedule recurrence applied to the block and to the window
    assign msg_next = small_sig1(msg_w[14]) + msg_w[9] + small_sig0(msg_w[1]) + msg_w[0];
    assign win_next = small_sig1(win_q[14]) + win_q[9] + small_sig0(win_q[1]) + win_q[0];

    // Window load and shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_MSG; i++) win_q[i] <= '0;
        end else if (load_i) begin
            for (int i = 0; i < N_MSG - 1; i++) win_q[i] <= msg_w[i+1];
            win_q[N_MSG-1] <= msg_next;
        end else if (shift_i) begin
            for (int i = 0; i < N_MSG - 1; i++) win_q[i] <= win_q[i+1];
            win_q[N_MSG-1] <= win_next;
        end
    end

    assign head_o = win_q[0];

endmodule

// File: rtl/sha512_core.sv
// SHA-512 compression of one padded block, one round per clock. The
// constant + word + next-H (+ first chaining word on the last round) sum is
// registered one round ahead, so the new A is a five-operand sum.
// Assumes start_i is ignored while a run is active.
module sha512_core
    import sha512_core_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    first_i,
    input  logic [N_MSG*WORD_W-1:0] block_i,
    output logic                    done_o,
    output logic [8*WORD_W-1:0]     hash_o
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    word_t             work_q  [8];
    word_t             chain_q [8];
    word_t             base_ld [8];
    word_t             base_rn [8];
    word_t             pre_a_q;
    word_t             pre_e_q;
    logic              busy_q;
    logic              first_q;
    logic              done_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nx;

    logic  accept;
    logic  last;
    word_t w_head;
    word_t w_zero;
    word_t s0_v, mj_v, s1_v, ch_v;
    word_t a_new, e_new;
    word_t kwh_nx, pre0;

    assign accept  = start_i & ~busy_q;
    assign last    = busy_q & (step_q == LAST);
    assign step_nx = step_q + STEP_W'(1);
    assign w_zero  = block_i[N_MSG*WORD_W-1 -: WORD_W];

    // Feed-forward base: initial value or the held chaining value
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            base_ld[i] = first_i ? init_word(i) : chain_q[i];
            base_rn[i] = first_q ? init_word(i) : chain_q[i];
        end
    end

    sha512_expander u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .shift_i(busy_q),
        .block_i(block_i),
        .head_o (w_head)
    );

    // Round logic on the current working words
    assign s0_v = big_sig0(work_q[0]);
    assign mj_v = majority(work_q[0], work_q[1], work_q[2]);
    assign s1_v = big_sig1(work_q[4]);
    assign ch_v = choose(work_q[4], work_q[5], work_q[6]);

    sha512_add5 #(.W(WORD_W)) u_add_a (
        .ops_i({s0_v, mj_v, s1_v, ch_v, pre_a_q}),
        .sum_o(a_new)
    );

    assign e_new  = work_q[3] + s1_v + ch_v + pre_e_q;
    assign kwh_nx = step_const(step_nx) + w_head + work_q[6];
    assign pre0   = step_const('0) + w_zero + base_ld[7];

    // Control: accept, step count, completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
            step_q  <= '0;
        end else begin
            done_q <= last;
            if (accept) begin
                busy_q  <= 1'b1;
                first_q <= first_i;
                step_q  <= '0;
            end else if (busy_q) begin
                step_q <= step_nx;
                if (last) busy_q <= 1'b0;
            end
        end
    end

    // Working words and precomputed operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) work_q[i] <= '0;
            pre_a_q <= '0;
            pre_e_q <= '0;
        end else if (accept) begin
            for (int i = 0; i < 8; i++) work_q[i] <= base_ld[i];
            pre_a_q <= pre0;
            pre_e_q <= pre0;
        end else if (busy_q) begin
            work_q[0] <= a_new;
            work_q[1] <= work_q[0];
            work_q[2] <= work_q[1];
            work_q[3] <= work_q[2];
            work_q[4] <= e_new;
            work_q[5] <= work_q[4];
            work_q[6] <= work_q[5];
            work_q[7] <= work_q[6];
            pre_e_q   <= kwh_nx;
            pre_a_q   <= kwh_nx + ((step_nx == LAST) ? base_rn[0] : '0);
        end
    end

    // Chaining value: written only when the last round completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) chain_q[i] <= '0;
        end else if (last) begin
            chain_q[0] <= a_new;
            chain_q[1] <= work_q[0] + base_rn[1];
            chain_q[2] <= work_q[1] + base_rn[2];
            chain_q[3] <= work_q[2] + base_rn[3];
            chain_q[4] <= e_new     + base_rn[4];
            chain_q[5] <= work_q[4] + base_rn[5];
            chain_q[6] <= work_q[5] + base_rn[6];
            chain_q[7] <= work_q[6] + base_rn[7];
        end
    end

    for (genvar i = 0; i < 8; i++) begin : g_out
        assign hash_o[8*WORD_W-1-WORD_W*i -: WORD_W] = chain_q[i];
    end

    assign done_o = done_q;

endmodule

// File: rtl/sha512_core_chk.sv
// Protocol checker for sha512_core: completion pulse, result hold and
// start acceptance. Attached to the core with a bind below.
module sha512_core_chk
    import sha512_core_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                done_o,
    input logic                busy_i,
    input logic [STEP_W-1:0]   step_i,
    input logic [8*WORD_W-1:0] hash_o
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    // R4: completion lasts one cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: completion follows the last round of a run
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_i) && $past(step_i) == LAST));

    // R4: step counter stays within the round range
    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (step_i <= LAST));

    // R5: result changes only with the completion pulse
    assert_hash_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(hash_o));

    // R6: a start during a run does not restart it
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && start_i && step_i != LAST) |=> (busy_i && step_i == $past(step_i) + STEP_W'(1)));

endmodule

bind sha512_core sha512_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .done_o (done_o),
    .busy_i (busy_q),
    .step_i (step_q),
    .hash_o (hash_o)
);

// File: tb/sha512_core_bench.sv
// Bench for sha512_core: directed vector, random blocks against a bench
// compression model, chaining, restart rules and the five-operand adder.
module sha512_core_bench;
    import sha512_core_pkg::step_const;

    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          first_i = 1'b0;
    logic [1023:0] block_i = '0;
    logic          done_o;
    logic [511:0]  hash_o;

    logic [4:0][63:0] t_ops;
    logic [63:0]      t_sum;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha512_core u_sha512_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_i(first_i),
        .block_i(block_i), .done_o(done_o), .hash_o(hash_o)
    );

    sha512_add5 #(.W(64)) u_add5 (.ops_i(t_ops), .sum_o(t_sum));

    // ---------------- reference model ----------------
    function automatic logic [63:0] rr(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [511:0] iv512();
        return {64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b, 64'h3c6ef372fe94f82b,
                64'ha54ff53a5f1d36f1, 64'h510e527fade682d1, 64'h9b05688c2b3e6c1f,
                64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};
    endfunction

    function automatic logic [511:0] ref_compress(input logic [511:0] h, input logic [1023:0] blk);
        logic [63:0] w [80];
        logic [63:0] v [8];
        logic [63:0] t1, t2;
        logic [511:0] r;
        for (int i = 0; i < 16; i++) w[i] = blk[1023-64*i -: 64];
        for (int i = 16; i < 80; i++)
            w[i] = (rr(w[i-2],19) ^ rr(w[i-2],61) ^ (w[i-2] >> 6)) + w[i-7]
                 + (rr(w[i-15],1) ^ rr(w[i-15],8) ^ (w[i-15] >> 7)) + w[i-16];
        for (int i = 0; i < 8; i++) v[i] = h[511-64*i -: 64];
        for (int t = 0; t < 80; t++) begin
            t1 = v[7] + (rr(v[4],14) ^ rr(v[4],18) ^ rr(v[4],41))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + step_const(7'(t)) + w[t];
            t2 = (rr(v[0],28) ^ rr(v[0],34) ^ rr(v[0],39))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) r[511-64*i -: 64] = v[i] + h[511-64*i -: 64];
        return r;
    endfunction

    function automatic logic [1023:0] rand_block();
        logic [1023:0] b;
        for (int i = 0; i < 32; i++) b[32*i +: 32] = $urandom;
        return b;
    endfunction

    // ---------------- check helpers ----------------
    task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one block starting at the current negedge. Optionally raises a
    // second start mid-run (inj) and checks the held result at cycle 40.
    task automatic run_block(input logic [1023:0] blk, input logic fst, input bit inj,
                             input string req, output logic [511:0] res);
        logic [511:0] prev;
        bit timing_ok;
        prev = hash_o;
        timing_ok = 1;
        start_i = 1'b1; first_i = fst; block_i = blk;
        @(negedge clk);
        start_i = 1'b0; first_i = 1'b0; block_i = '0;
        for (int k = 1; k <= 80; k++) begin
            if (inj && k == 30) begin
                start_i = 1'b1; first_i = ~fst; block_i = ~blk;
            end
            if (inj && k == 31) begin
                start_i = 1'b0; first_i = 1'b0; block_i = '0;
            end
            @(negedge clk);
            if (k < 80 && done_o !== 1'b0) timing_ok = 0;
            if (k == 40)
                check(hash_o === prev, {req, " R5 hold during run"}, hash_o, prev);
        end
        check(timing_ok && done_o === 1'b1, {req, " R4 done at cycle 80"},
              {511'b0, done_o}, {511'b0, 1'b1});
        res = hash_o;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [511:0] res, exp, h1;
        logic [1023:0] blk, blk2;
        logic [63:0] pl;
        void'($urandom(32'h5a17c0de));

        repeat (3) @(negedge clk);
        // R1: reset state
        check(done_o === 1'b0, "R1 done low in reset", {511'b0, done_o}, '0);
        check(hash_o === '0, "R1 hash zero in reset", hash_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0 && hash_o === '0, "R1 state after release", hash_o, '0);

        // R2: published one-block vector
        blk = {24'h616263, 8'h80, 928'b0, 64'd24};
        exp = {64'hddaf35a193617aba, 64'hcc417349ae204131, 64'h12e6fa4e89a97ea2,
               64'h0a9eeee64b55d39a, 64'h2192992a274fc1a8, 64'h36ba3c23a3feebbd,
               64'h454d4423643ce80e, 64'h2a9ac94fa54ca49f};
        run_block(blk, 1'b1, 0, "R2 abc", res);
        check(res === exp, "R2 abc digest", res, exp);
        check(ref_compress(iv512(), blk) === exp, "R2 bench model abc", ref_compress(iv512(), blk), exp);
        @(negedge clk);
        check(done_o === 1'b0, "R4 done drops after one cycle", {511'b0, done_o}, '0);
        check(hash_o === exp, "R5 result held after pulse", hash_o, exp);

        // R8 and R2: random first blocks
        for (int n = 0; n < 5; n++) begin
            blk = rand_block();
            if (n == 0) blk = '0;
            if (n == 1) blk = '1;
            run_block(blk, 1'b1, 0, "R8 random first", res);
            exp = ref_compress(iv512(), blk);
            check(res === exp, "R8 random block digest", res, exp);
            @(negedge clk);
        end

        // R3: chained second blocks from the previous result
        for (int n = 0; n < 3; n++) begin
            h1 = hash_o;
            blk = rand_block();
            run_block(blk, 1'b0, 0, "R3 chained", res);
            exp = ref_compress(h1, blk);
            check(res === exp, "R3 chained digest", res, exp);
            @(negedge clk);
        end

        // R6: a second start mid-run is ignored
        blk = rand_block();
        run_block(blk, 1'b1, 1, "R6 mid-run start", res);
        exp = ref_compress(iv512(), blk);
        check(res === exp, "R6 result of original start", res, exp);
        @(negedge clk);
        check(done_o === 1'b0, "R6 no extra pulse", {511'b0, done_o}, '0);

        // R9: start in the done cycle, back-to-back
        blk = rand_block();
        run_block(blk, 1'b1, 0, "R9 first of pair", res);
        h1 = res;
        blk2 = rand_block();
        run_block(blk2, 1'b0, 0, "R9 back-to-back", res);
        exp = ref_compress(h1, blk2);
        check(res === exp, "R9 back-to-back digest", res, exp);
        @(negedge clk);

        // R7: five-operand adder against a plain sum
        for (int n = 0; n < 300; n++) begin
            for (int j = 0; j < 5; j++) t_ops[j] = {$urandom, $urandom};
            if (n == 0) t_ops = '1;
            if (n == 1) t_ops = '0;
            if (n == 2) for (int j = 0; j < 5; j++) t_ops[j] = 64'h8000000000000001;
            #1;
            pl = t_ops[0] + t_ops[1] + t_ops[2] + t_ops[3] + t_ops[4];
            check(t_sum === pl, "R7 adder sum", {448'b0, t_sum}, {448'b0, pl});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule